// File: doc/BRIEF.md
# Weighted High/Low Packet Arbiter

This block chooses, one whole packet at a time, whether the transmitter next takes its packet from a high-priority queue or from a low-priority queue. It sees only a "not empty" flag per queue, a strobe that marks the end of the packet now in flight, and a 3-bit weight code. It answers with a grant per queue and a combined valid flag. Packet data, descriptors and memory traffic stay outside. The block only counts packets and hands out grants.

The weight code sets how many high packets are sent for each low packet. Code 0 gives one high packet, then one low packet. Codes 1 to 6 give twice the code value in high packets (2, 4, 6, 8, 10 or 12) before each low packet. Code 7 is strict priority: the low queue is served only while the high queue is empty. A credit counter tracks the high packets sent since the last low packet. The counter is cleared whenever the high queue is seen empty. This means a fresh run of high credit starts when high traffic returns.

A grant is issued in the cycle after an idle cycle in which a queue is pending. The grant holds until the packet-done strobe is seen. It then drops for exactly one cycle, and the next choice is made in that idle cycle. The weight code is used only in the idle cycle where the choice is made.

Top module: `wqa_arbiter`

## Requirements
- R1: While reset is active and in the first cycle after it, neither grant is asserted and `grant_valid` is low.
- R2: With weight code 0 and both queues pending, grants alternate: one high (H), then one low (L), repeating (H L H L ...).
- R3: With weight codes 1 to 6 and both queues pending, each low grant follows exactly 2×code consecutive high grants.
- R4: With weight code 7, a low grant is issued only when the high queue is not pending. While the high queue is pending, every grant goes to it.
- R5: When the high queue is empty and the low queue is pending at a choice, the low queue is granted. The next high run then gets its full credit.
- R6: If the high queue goes empty while credit remains, the credit is cleared. When both queues return, a full run of 2×code (or 1 for code 0) high packets is granted before the next low packet.
- R7: At most one grant is asserted at a time. A grant stays constant from the cycle it appears until `pkt_done` is sampled high.
- R8: With the low queue empty, high packets keep being granted without limit. The credit count saturates rather than wrapping. So after 17 high grants at code 6, a newly pending low queue is served next.
- R9: The weight code matters only in the idle cycle where a choice is made. Changing it while a grant is held has no effect on that grant or on the next choice, as long as it is restored before the choice.
- R10: With neither queue pending, no grant is issued. `grant_valid` equals the OR of the two grants.
- R11: In the cycle after `pkt_done` is sampled with a grant held, `grant_valid` is low. The next grant can appear one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_pending | input | 1 | High-priority queue holds at least one packet |
| lo_pending | input | 1 | Low-priority queue holds at least one packet |
| pkt_done | input | 1 | Packet now granted has finished (sampled only while a grant is held) |
| weight_code | input | 3 | High-to-low ratio code: 0 → 1:1, 1..6 → 2×code:1, 7 → strict priority |
| grant_hi | output | 1 | Current packet comes from the high queue |
| grant_lo | output | 1 | Current packet comes from the low queue |
| grant_valid | output | 1 | A grant is held |

## Verification
The checker watches several things on every clock cycle:
- the two grants are never active together;
- a grant is held stable until `pkt_done` and released one cycle after it;
- no grant arises from empty queues;
- a strict code, an empty high queue or an empty low queue forces the next choice;
- the block is quiet after reset.

Some properties depend on the packet history, so only the bench's scenarios can show them:
- the exact high-to-low ratios for each code;
- the credit reset when the high queue empties;
- saturation after long high-only runs;
- the fact that a weight change in the middle of a packet does nothing.

A behavioural model compares both grants every cycle in all of these scenarios.

// File: rtl/wqa_pkg.sv
// Shared types for the weighted high/low packet arbiter.
package wqa_pkg;
    // Outcome of one arbitration choice.
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_HI   = 2'd1,
        PICK_LO   = 2'd2
    } pick_e;
endpackage

// File: rtl/wqa_weight_decode.sv
// Weight decoder.
// Turns the weight code into a credit limit (high packets per low packet) and a
// strict-priority flag.
// Assumes: code 0 means a limit of 1, codes 1..max-1 mean 2*code, and all-ones means strict.
module wqa_weight_decode #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit,
    output logic              strict
);
    localparam logic [CODE_W-1:0] STRICT_CODE = '1;
    localparam logic [CODE_W-1:0] ONE_TO_ONE  = '0;

    // Map the code onto a limit and flag the strict setting.
    always_comb begin
        strict = (code == STRICT_CODE);
        if (code == ONE_TO_ONE) begin
            limit = CNT_W'(1);
        end else begin
            limit = CNT_W'({code, 1'b0});
        end
    end
endmodule

// File: rtl/wqa_credit_counter.sv
// High-credit counter.
// Counts the high packets granted since the last low grant or since the high
// queue was last seen empty.
// Assumes: take_hi and clear never matter together; take_hi wins if they do.
// The count saturates at all-ones.
module wqa_credit_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_hi,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Saturating increment on a high grant; clear on a low grant or an empty high queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (take_hi) begin
            if (count != CNT_MAX) begin
                count <= count + 1'b1;
            end
        end else if (clear) begin
            count <= '0;
        end
    end
endmodule

// File: rtl/wqa_pick.sv
// Choice logic.
// Combinational decision on which queue the next packet should come from.
// Assumes: the result is used only while no grant is held.
module wqa_pick
    import wqa_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             hi_pending,
    input  logic             lo_pending,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] limit,
    input  logic             strict,
    output pick_e            pick
);
    // Prefer high while credit remains, when strict, or when low is empty.
    always_comb begin
        if (hi_pending) begin
            if (strict || !lo_pending || (count < limit)) begin
                pick = PICK_HI;
            end else begin
                pick = PICK_LO;
            end
        end else if (lo_pending) begin
            pick = PICK_LO;
        end else begin
            pick = PICK_NONE;
        end
    end
endmodule

// File: rtl/wqa_grant_hold.sv
// Grant register.
// Loads a choice while idle and holds it until the packet-done strobe arrives.
// Assumes: pkt_done is meaningful only while a grant is held.
module wqa_grant_hold
    import wqa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pick_e pick,
    input  logic  pkt_done,
    output logic  grant_hi,
    output logic  grant_lo
);
    logic held;
    assign held = grant_hi | grant_lo;

    // Hold the current grant until done; load a new choice only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_hi <= 1'b0;
            grant_lo <= 1'b0;
        end else if (held) begin
            if (pkt_done) begin
                grant_hi <= 1'b0;
                grant_lo <= 1'b0;
            end
        end else begin
            grant_hi <= (pick == PICK_HI);
            grant_lo <= (pick == PICK_LO);
        end
    end
endmodule

// File: rtl/wqa_arbiter.sv
// Weighted high/low packet arbiter (top).
// Grants whole packets to a high or a low queue in the ratio set by the weight code.
// Code 0 gives 1:1, codes 1..6 give 2*code:1, and the all-ones code gives strict priority.
// Assumes: the pending flags reflect queue occupancy, and pkt_done pulses once per granted packet.
module wqa_arbiter
    import wqa_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_pending,
    input  logic              lo_pending,
    input  logic              pkt_done,
    input  logic [CODE_W-1:0] weight_code,
    output logic              grant_hi,
    output logic              grant_lo,
    output logic              grant_valid
);
    localparam int LIMIT_MAX = 2 * ((1 << CODE_W) - 2);
    localparam int CNT_W     = $clog2(LIMIT_MAX + 1);

    logic [CNT_W-1:0] limit;
    logic             strict;
    logic [CNT_W-1:0] count;
    pick_e            pick;
    logic             idle;
    logic             take_hi;
    logic             take_lo;
    logic             credit_clear;

    wqa_weight_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .code   (weight_code),
        .limit  (limit),
        .strict (strict)
    );

    wqa_pick #(.CNT_W(CNT_W)) u_pick (
        .hi_pending (hi_pending),
        .lo_pending (lo_pending),
        .count      (count),
        .limit      (limit),
        .strict     (strict),
        .pick       (pick)
    );

    // Choices take effect only from an idle cycle.
    assign idle         = !(grant_hi || grant_lo);
    assign take_hi      = idle && (pick == PICK_HI);
    assign take_lo      = idle && (pick == PICK_LO);
    assign credit_clear = take_lo || (!hi_pending && !grant_hi);

    wqa_credit_counter #(.CNT_W(CNT_W)) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_hi (take_hi),
        .clear   (credit_clear),
        .count   (count)
    );

    wqa_grant_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick     (pick),
        .pkt_done (pkt_done),
        .grant_hi (grant_hi),
        .grant_lo (grant_lo)
    );

    assign grant_valid = grant_hi | grant_lo;
endmodule

// File: rtl/wqa_arbiter_checker.sv
// Property checker for wqa_arbiter, attached with bind below.
module wqa_arbiter_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_pending,
    input logic              lo_pending,
    input logic              pkt_done,
    input logic [CODE_W-1:0] weight_code,
    input logic              grant_hi,
    input logic              grant_lo,
    input logic              grant_valid
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !grant_valid);

    assert_strict_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && hi_pending && (&weight_code)) |=> grant_hi);

    assert_empty_high_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !hi_pending && lo_pending) |=> grant_lo);

    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_hi && grant_lo));

    assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !pkt_done) |=> $stable({grant_hi, grant_lo}));

    assert_empty_low_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && hi_pending && !lo_pending) |=> grant_hi);

    assert_no_phantom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !hi_pending && !lo_pending) |=> !grant_valid);

    assert_valid_is_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant_hi || grant_lo));

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && pkt_done) |=> !grant_valid);
endmodule

bind wqa_arbiter wqa_arbiter_checker #(.CODE_W(CODE_W)) i_wqa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_pending  (hi_pending),
    .lo_pending  (lo_pending),
    .pkt_done    (pkt_done),
    .weight_code (weight_code),
    .grant_hi    (grant_hi),
    .grant_lo    (grant_lo),
    .grant_valid (grant_valid)
);

// File: tb/test_wqa_arbiter.sv
`timescale 1ns/1ps
module test_wqa_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hi_pending = 1'b0;
    logic       lo_pending = 1'b0;
    logic       pkt_done = 1'b0;
    logic [2:0] weight_code = 3'd0;
    logic       grant_hi;
    logic       grant_lo;
    logic       grant_valid;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wqa_arbiter i_wqa_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_pending  (hi_pending),
        .lo_pending  (lo_pending),
        .pkt_done    (pkt_done),
        .weight_code (weight_code),
        .grant_hi    (grant_hi),
        .grant_lo    (grant_lo),
        .grant_valid (grant_valid)
    );

    // Behavioural reference: grant state 0 none, 1 high, 2 low; credit as an integer.
    int m_grant = 0;
    int m_cnt   = 0;

    function automatic int lim_of(input int code);
        return (code == 0) ? 1 : 2 * code;
    endfunction

    always @(posedge clk) begin : model
        int ng;
        int nc;
        if (!rst_n) begin
            m_grant = 0;
            m_cnt   = 0;
        end else begin
            ng = m_grant;
            nc = m_cnt;
            if (m_grant == 0) begin
                if (hi_pending) begin
                    if (weight_code == 3'd7 || !lo_pending || m_cnt < lim_of(int'(weight_code))) begin
                        ng = 1;
                        nc = (m_cnt < 15) ? m_cnt + 1 : 15;
                    end else begin
                        ng = 2;
                        nc = 0;
                    end
                end else if (lo_pending) begin
                    ng = 2;
                    nc = 0;
                end
            end else if (pkt_done) begin
                ng = 0;
            end
            if (!hi_pending && m_grant != 1 && ng != 1) nc = 0;
            m_grant = ng;
            m_cnt   = nc;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        logic eh, el;
        eh = (m_grant == 1);
        el = (m_grant == 2);
        checks++;
        if (grant_hi !== eh || grant_lo !== el || grant_valid !== (eh | el)) begin
            errors++;
            $display("FAIL %s model compare t=%0t: actual hi=%b lo=%b v=%b expected hi=%b lo=%b v=%b",
                     cur_req, $time, grant_hi, grant_lo, grant_valid, eh, el, eh | el);
        end
    end

    task automatic check(input string req, input bit ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    function automatic string pattern(input int lim, input int n);
        string s = "";
        for (int i = 0; i < n; i++) s = {s, ((i % (lim + 1)) < lim) ? "H" : "L"};
        return s;
    endfunction

    // Serve n packets, each len cycles long; record the queue order and check hold/release (R7, R11).
    task automatic serve(input int n, input int len, inout string seq);
        for (int p = 0; p < n; p++) begin
            int  waitc = 0;
            bit  was_hi;
            while (!grant_valid && waitc < 50) begin
                @(negedge clk);
                waitc++;
            end
            if (!grant_valid) begin
                seq = {seq, "-"};
                return;
            end
            was_hi = grant_hi;
            seq = {seq, was_hi ? "H" : "L"};
            for (int k = 1; k < len; k++) begin
                @(negedge clk);
                check("R7", grant_valid && grant_hi == was_hi, $sformatf("hi=%b v=%b", grant_hi, grant_valid),
                      $sformatf("hi=%b v=1", was_hi));
            end
            pkt_done = 1'b1;
            @(negedge clk);
            pkt_done = 1'b0;
            check("R11", !grant_valid, $sformatf("v=%b", grant_valid), "v=0");
        end
    endtask

    task automatic quiesce();
        hi_pending = 1'b0;
        lo_pending = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        string s;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", !grant_valid && !grant_hi && !grant_lo, $sformatf("v=%b", grant_valid), "v=0");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !grant_valid, $sformatf("v=%b", grant_valid), "v=0");

        cur_req = "R10";
        repeat (5) @(negedge clk);
        check("R10", !grant_valid, $sformatf("v=%b", grant_valid), "v=0");

        cur_req = "R2";
        weight_code = 3'd0; hi_pending = 1'b1; lo_pending = 1'b1;
        s = ""; serve(6, 1, s);
        check("R2", s == "HLHLHL", s, "HLHLHL");
        quiesce();

        cur_req = "R3";
        for (int c = 1; c <= 6; c++) begin
            string e;
            weight_code = 3'(c); hi_pending = 1'b1; lo_pending = 1'b1;
            s = ""; serve(2 * (2 * c + 1), (c == 3) ? 4 : 1, s);
            e = pattern(2 * c, 2 * (2 * c + 1));
            check("R3", s == e, s, e);
            quiesce();
        end

        cur_req = "R4";
        weight_code = 3'd7; hi_pending = 1'b1; lo_pending = 1'b1;
        s = ""; serve(8, 1, s);
        check("R4", s == "HHHHHHHH", s, "HHHHHHHH");
        hi_pending = 1'b0;
        s = ""; serve(2, 1, s);
        check("R4", s == "LL", s, "LL");
        quiesce();

        cur_req = "R5";
        weight_code = 3'd2; hi_pending = 1'b1; lo_pending = 1'b1;
        s = ""; serve(3, 1, s);
        hi_pending = 1'b0;
        serve(1, 1, s);
        hi_pending = 1'b1;
        serve(5, 1, s);
        check("R5", s == "HHHLHHHHL", s, "HHHLHHHHL");
        quiesce();

        cur_req = "R6";
        weight_code = 3'd2; hi_pending = 1'b1; lo_pending = 1'b1;
        s = ""; serve(2, 1, s);
        hi_pending = 1'b0; lo_pending = 1'b0;
        repeat (3) @(negedge clk);
        hi_pending = 1'b1; lo_pending = 1'b1;
        serve(5, 1, s);
        check("R6", s == "HHHHHHL", s, "HHHHHHL");
        quiesce();

        cur_req = "R8";
        weight_code = 3'd6; hi_pending = 1'b1; lo_pending = 1'b0;
        s = ""; serve(17, 1, s);
        lo_pending = 1'b1;
        serve(1, 1, s);
        check("R8", s == {pattern(17, 17), "L"}, s, {pattern(17, 17), "L"});
        quiesce();

        cur_req = "R9";
        weight_code = 3'd0; hi_pending = 1'b1; lo_pending = 1'b1;
        @(negedge clk);
        check("R9", grant_hi, $sformatf("hi=%b", grant_hi), "hi=1");
        weight_code = 3'd7;
        repeat (2) @(negedge clk);
        check("R9", grant_hi && !grant_lo, $sformatf("hi=%b lo=%b", grant_hi, grant_lo), "hi=1 lo=0");
        weight_code = 3'd0;
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        @(negedge clk);
        check("R9", grant_lo, $sformatf("lo=%b", grant_lo), "lo=1");
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        quiesce();

        cur_req = "R10";
        repeat (4) @(negedge clk);
        check("R10", !grant_valid, $sformatf("v=%b", grant_valid), "v=0");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule